// File: doc/BRIEF.md
# UART Transmitter with Break Generation

This block is the serial sending half of an asynchronous serial port. When a byte is waiting in an external transmit buffer, the block takes it with a one-cycle pop strobe and shifts it out on the TX line. The frame is a start bit, then the data bits with the least significant bit first, then an optional parity bit, then the stop bits. The word length, the parity mode (odd, even or stick) and the stop-bit count are programmable. The frame settings are captured when a character starts, so a change made mid-character takes effect on the next one.

Bit timing comes from an external baud tick that pulses `OS` times per bit. This oversampling lets the block produce a stop interval of one and a half bits. Two line controls sit beside the framer. A forced-space control holds the pin low without disturbing the framer. A LIN break generator sends a low field of programmable length, followed by one high delimiter bit.

Optional CTS flow control holds back new characters while the synchronised CTS input is away from its programmable active level. A character that has already started always completes. Any change on the synchronised CTS is recorded in a sticky flag. Two status outputs report progress: holding-empty says the buffer has no byte waiting, and transmitter-empty adds that the last frame has fully left the pin.

Top module: `uart_tx_break`

## Requirements
- R1: Each character is sent as one low start bit, then the data bits least significant first, then stop bits at 1. The word-length code 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits. Each bit lasts `OS` baud ticks. The line idles at 1. `buf_pop` pulses for one cycle per character, and only while `buf_valid` is 1.
- R2: With `cfg_stop_sel` = 0 the frame ends with 1 stop bit. With `cfg_stop_sel` = 1 it ends with 2 stop bits for 6, 7 or 8 data bits, and with 1.5 stop bits (`OS`+`OS`/2 ticks) for 5 data bits.
- R3: With `cfg_par_en` = 1, a parity bit follows the last data bit. With `cfg_par_even` = 1 the count of ones in the data and parity bits is even; with 0 it is odd.
- R4: With `cfg_par_en` = 1 and `cfg_par_stick` = 1, the parity bit is 1 when `cfg_par_even` = 0 and 0 when `cfg_par_even` = 1, whatever the data.
- R5: While `cfg_break_force` = 1, `tx_out` is 0 from the next cycle onward. Characters are still popped and framed with unchanged timing, so `tx_empty` rises when it would without the break.
- R6: With `cfg_cts_flow_en` = 1, no character starts (no `buf_pop`) while the synchronised CTS differs from `cfg_cts_active_high` (1 = active high, 0 = active low). Sending resumes once CTS returns to its active level.
- R7: A character already started completes in full even when CTS goes inactive during it, and the next buffered character then waits for CTS.
- R8: `cts_chg_flag` is set by any rising or falling edge of the synchronised CTS. It is cleared by a one-cycle pulse on `cts_chg_clr`, and it is 0 after reset.
- R9: A pulse on `lin_start` sets `lin_active`. At the next idle point the line is driven low for `lin_len`+2 bit times, then high for one delimiter bit. `lin_active` clears itself at the end of the delimiter. No character is popped while `lin_active` is 1.
- R10: `hold_empty` is 1 when no byte is waiting in the buffer. `tx_empty` is 1 only when no byte is waiting and the last stop bit (and any LIN field) has been fully sent. It stays 0 through the stop bit.
- R11: After reset, `tx_out`, `hold_empty` and `tx_empty` are 1, and `buf_pop`, `cts_chg_flag` and `lin_active` are 0. While `tx_empty` is 1 and no break is forced, `tx_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse, `OS` per bit time |
| cfg_word_len | input | 2 | Data bits minus 5 |
| cfg_stop_sel | input | 1 | Long stop interval select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | Even parity select (inverted stick value) |
| cfg_par_stick | input | 1 | Stick parity enable |
| cfg_break_force | input | 1 | Force TX pin low |
| cfg_cts_flow_en | input | 1 | CTS gating of new characters |
| cfg_cts_active_high | input | 1 | CTS active level |
| cts_in | input | 1 | Asynchronous clear-to-send input |
| cts_chg_clr | input | 1 | Clears the CTS change flag |
| cts_chg_flag | output | 1 | Sticky CTS edge flag |
| lin_start | input | 1 | Requests a LIN break field |
| lin_len | input | 4 | Break length minus 2, in bits |
| lin_active | output | 1 | LIN break requested or in progress |
| buf_valid | input | 1 | Buffer holds a byte |
| buf_data | input | 8 | Byte at the buffer head |
| buf_pop | output | 1 | Takes the head byte |
| tx_out | output | 1 | Serial output line |
| hold_empty | output | 1 | No byte waiting |
| tx_empty | output | 1 | Buffer empty and line idle |

## Verification
The bench builds the block with `OS` = 8 and sends a baud tick every second clock, so one bit lasts 16 clocks. At this setting a half bit (8 clocks) is much longer than the one-clock phase slip between tick and state change. As a result, the 1, 1.5 and 2 stop-bit cases can be told apart by measuring start-to-start spacing of back-to-back characters, and mid-bit sampling stays unambiguous. The short bit time also makes a 17-bit LIN field and several hundred clocks of CTS stall cheap. This lets the bench cover the longest break length, both CTS polarities and a stall in the middle of a burst.

// File: rtl/uart_txb_pkg.sv
package uart_txb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_LINBRK,
        ST_LINDLM
    } txb_state_e;

    typedef struct packed {
        logic [1:0] word_len;
        logic       stop_sel;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } txb_frame_cfg_t;

    localparam int unsigned TXB_DATA_W  = 8;
    localparam int unsigned TXB_LEN_W   = 4;
    localparam int unsigned TXB_BRK_ADD = 2;

    // number of data bits for a word-length code
    function automatic logic [3:0] txb_data_bits(input logic [1:0] wl);
        return 4'd5 + {2'b00, wl};
    endfunction

    // mask keeping only the transmitted data bits
    function automatic logic [7:0] txb_data_mask(input logic [1:0] wl);
        return 8'hFF >> (3'd3 - {1'b0, wl});
    endfunction

    function automatic logic txb_parity(input logic [7:0] d, input txb_frame_cfg_t c);
        logic ones;
        ones = ^(d & txb_data_mask(c.word_len));
        if (c.par_stick) begin
            return ~c.par_even;
        end else if (c.par_even) begin
            return ones;
        end
        return ~ones;
    endfunction

    // stop interval length in baud ticks
    function automatic int unsigned txb_stop_ticks(input txb_frame_cfg_t c, input int unsigned os);
        if (!c.stop_sel) begin
            return os;
        end else if (c.word_len == 2'd0) begin
            return os + os / 2;
        end
        return 2 * os;
    endfunction

endpackage

// File: rtl/txb_cts_sync.sv
module txb_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cts_in,
    input  logic flow_en,
    input  logic active_high,
    input  logic chg_clr,
    output logic cts_ok,
    output logic chg_flag
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level;
    logic              edge_seen;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= cts_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign level     = sync_q[STAGES-1];
    assign edge_seen = level ^ prev_q;
    assign cts_ok    = !flow_en || (level == active_high);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            chg_flag <= 1'b0;
        end else begin
            prev_q <= level;
            if (edge_seen)    chg_flag <= 1'b1;
            else if (chg_clr) chg_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/txb_tick_timer.sv
module txb_tick_timer #(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          tick,
    input  logic [LW-1:0] limit,
    output logic          done
);
    logic [LW-1:0] cnt;

    assign done = tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/txb_frame_fsm.sv
module txb_frame_fsm
    import uart_txb_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  txb_frame_cfg_t cfg,
    input  logic           lin_start,
    input  logic [3:0]     lin_len,
    input  logic           buf_valid,
    input  logic [7:0]     buf_data,
    input  logic           cts_ok,
    output logic           buf_pop,
    output logic           line,
    output logic           idle,
    output logic           lin_active
);
    localparam int unsigned BRK_MAX = (16 + TXB_BRK_ADD + 1) * OS;
    localparam int          LW      = $clog2(BRK_MAX + 1);

    txb_state_e     state;
    txb_frame_cfg_t cfg_q;
    logic [7:0]     shreg;
    logic           par_q;
    logic [2:0]     bit_idx;
    logic [3:0]     len_q;
    logic           lin_pend;
    logic [LW-1:0]  limit;
    logic           done;
    logic           clear_t;
    logic           start_data;
    logic           last_bit;

    always_comb begin
        case (state)
            ST_STOP:   limit = LW'(txb_stop_ticks(cfg_q, OS));
            ST_LINBRK: limit = LW'((32'(len_q) + TXB_BRK_ADD) * OS);
            default:   limit = LW'(OS);
        endcase
    end

    assign clear_t    = (state == ST_IDLE) || done;
    assign start_data = (state == ST_IDLE) && !lin_pend && buf_valid && cts_ok;
    assign buf_pop    = start_data;
    assign idle       = (state == ST_IDLE);
    assign lin_active = lin_pend;
    assign last_bit   = ({1'b0, bit_idx} == txb_data_bits(cfg_q.word_len) - 4'd1);

    txb_tick_timer #(.LW(LW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (clear_t),
        .tick  (tick),
        .limit (limit),
        .done  (done)
    );

    always_comb begin
        case (state)
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = par_q;
            ST_LINBRK: line = 1'b0;
            default:   line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cfg_q    <= '0;
            shreg    <= '0;
            par_q    <= 1'b0;
            bit_idx  <= '0;
            len_q    <= '0;
            lin_pend <= 1'b0;
        end else begin
            if (state == ST_LINDLM && done) lin_pend <= 1'b0;
            else if (lin_start)             lin_pend <= 1'b1;

            case (state)
                ST_IDLE: begin
                    if (lin_pend) begin
                        len_q <= lin_len;
                        state <= ST_LINBRK;
                    end else if (start_data) begin
                        cfg_q   <= cfg;
                        shreg   <= buf_data;
                        par_q   <= txb_parity(buf_data, cfg);
                        bit_idx <= '0;
                        state   <= ST_START;
                    end
                end
                ST_START: if (done) state <= ST_DATA;
                ST_DATA: begin
                    if (done) begin
                        shreg <= {1'b0, shreg[7:1]};
                        if (last_bit) state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                        else          bit_idx <= bit_idx + 3'd1;
                    end
                end
                ST_PARITY: if (done) state <= ST_STOP;
                ST_STOP:   if (done) state <= ST_IDLE;
                ST_LINBRK: if (done) state <= ST_LINDLM;
                ST_LINDLM: if (done) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_break.sv
module uart_tx_break
    import uart_txb_pkg::*;
#(
    parameter int OS          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic [1:0] cfg_word_len,
    input  logic       cfg_stop_sel,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_par_stick,
    input  logic       cfg_break_force,
    input  logic       cfg_cts_flow_en,
    input  logic       cfg_cts_active_high,
    input  logic       cts_in,
    input  logic       cts_chg_clr,
    output logic       cts_chg_flag,
    input  logic       lin_start,
    input  logic [3:0] lin_len,
    output logic       lin_active,
    input  logic       buf_valid,
    input  logic [7:0] buf_data,
    output logic       buf_pop,
    output logic       tx_out,
    output logic       hold_empty,
    output logic       tx_empty
);
    txb_frame_cfg_t cfg;
    logic           cts_ok;
    logic           fsm_line;
    logic           fsm_idle;

    assign cfg = '{word_len:  cfg_word_len,
                   stop_sel:  cfg_stop_sel,
                   par_en:    cfg_par_en,
                   par_even:  cfg_par_even,
                   par_stick: cfg_par_stick};

    txb_cts_sync #(.STAGES(SYNC_STAGES)) u_cts (
        .clk         (clk),
        .rst         (rst),
        .cts_in      (cts_in),
        .flow_en     (cfg_cts_flow_en),
        .active_high (cfg_cts_active_high),
        .chg_clr     (cts_chg_clr),
        .cts_ok      (cts_ok),
        .chg_flag    (cts_chg_flag)
    );

    txb_frame_fsm #(.OS(OS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (baud_tick),
        .cfg        (cfg),
        .lin_start  (lin_start),
        .lin_len    (lin_len),
        .buf_valid  (buf_valid),
        .buf_data   (buf_data),
        .cts_ok     (cts_ok),
        .buf_pop    (buf_pop),
        .line       (fsm_line),
        .idle       (fsm_idle),
        .lin_active (lin_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_out     <= 1'b1;
            hold_empty <= 1'b1;
            tx_empty   <= 1'b1;
        end else begin
            tx_out     <= cfg_break_force ? 1'b0 : fsm_line;
            hold_empty <= ~buf_valid;
            tx_empty   <= ~buf_valid && fsm_idle && ~lin_active;
        end
    end
endmodule

// File: rtl/txb_checker.sv
module txb_checker (
    input logic clk,
    input logic rst,
    input logic buf_valid,
    input logic buf_pop,
    input logic tx_out,
    input logic cfg_break_force,
    input logic tx_empty,
    input logic hold_empty,
    input logic cts_ok,
    input logic lin_active
);
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst) buf_pop |-> buf_valid); // R1
    AST_POP_SPACED: assert property (@(posedge clk) disable iff (rst) buf_pop |=> !buf_pop); // R1
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst) cfg_break_force |=> !tx_out); // R5
    AST_POP_CTS_OK: assert property (@(posedge clk) disable iff (rst) buf_pop |-> cts_ok); // R6
    AST_LIN_NO_POP: assert property (@(posedge clk) disable iff (rst) lin_active |-> !buf_pop); // R9
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst) tx_empty |-> hold_empty); // R10
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst) (tx_empty && !$past(cfg_break_force)) |-> tx_out); // R11
endmodule

bind uart_tx_break txb_checker u_chk (.*);

// File: tb/uart_tx_break_tb.sv
`timescale 1ns/1ps
module uart_tx_break_tb;
    localparam int OS     = 8;
    localparam int TDIV   = 2;
    localparam int BITCLK = OS * TDIV;

    typedef struct {
        logic [7:0] d;
        int         nb;
        bit         pe;
        bit         pv;
        bit         stick;
        int         flen;
        bit         chk;
    } exp_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1;
    logic       baud_tick;
    logic [1:0] wl = 2'd3;
    logic       ss = 1'b0, pe = 1'b0, pev = 1'b0, pst = 1'b0;
    logic       brk = 1'b0, flow = 1'b0, acth = 1'b0;
    logic       cts_in = 1'b0, cts_clr = 1'b0;
    logic       cts_flag;
    logic       lin_start = 1'b0;
    logic [3:0] lin_len = 4'd0;
    logic       lin_active;
    logic       buf_valid = 1'b0;
    logic [7:0] buf_data = 8'h00;
    logic       buf_pop, tx_out, hold_empty, tx_empty;

    int   tcnt = 0;
    int   cyc = 0;
    int   pops = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    bit   mon_en = 1;
    bit   mon_busy = 0;
    logic [7:0] bq[$];
    exp_t       eq[$];

    assign baud_tick = (tcnt == TDIV - 1);

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
        if (buf_pop && bq.size() != 0) begin
            void'(bq.pop_front());
            pops <= pops + 1;
        end
    end

    always @(negedge clk) begin
        buf_valid <= (bq.size() != 0);
        buf_data  <= (bq.size() != 0) ? bq[0] : 8'h00;
    end

    uart_tx_break #(.OS(OS), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .cfg_word_len(wl), .cfg_stop_sel(ss), .cfg_par_en(pe),
        .cfg_par_even(pev), .cfg_par_stick(pst), .cfg_break_force(brk),
        .cfg_cts_flow_en(flow), .cfg_cts_active_high(acth),
        .cts_in(cts_in), .cts_chg_clr(cts_clr), .cts_chg_flag(cts_flag),
        .lin_start(lin_start), .lin_len(lin_len), .lin_active(lin_active),
        .buf_valid(buf_valid), .buf_data(buf_data), .buf_pop(buf_pop),
        .tx_out(tx_out), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic ncyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: expected frame from the requirements, byte into the buffer
    task automatic push_byte(input logic [7:0] d, input bit chk);
        exp_t e;
        int   st;
        e.nb    = 5 + int'(wl);
        e.d     = d & (8'hFF >> (8 - e.nb));
        e.pe    = pe;
        e.stick = pst;
        e.pv    = pst ? ~pev : (pev ? ^e.d : ~(^e.d));
        st      = !ss ? OS : ((wl == 2'd0) ? OS + OS / 2 : 2 * OS);
        e.flen  = ((1 + e.nb + int'(pe)) * OS + st) * TDIV;
        e.chk   = chk;
        eq.push_back(e);
        bq.push_back(d);
    endtask

    task automatic wait_done();
        int t = 0;
        while ((eq.size() != 0 || mon_busy || bq.size() != 0 || !tx_empty) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        ncyc(BITCLK);
    endtask

    task automatic wait_pop_to(input int left);
        int t = 0;
        while (bq.size() > left && t < 20000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // monitor: decode each frame and compare with the scoreboard
    initial begin
        bit   last_tx = 1'b1;
        int   prev_edge = 0;
        int   prev_len = 0;
        bit   prev_chk = 0;
        exp_t e;
        logic [7:0] got;
        int   now;
        forever begin
            @(negedge clk);
            if (mon_en && last_tx && !tx_out) begin
                now = cyc;
                if (prev_chk)
                    check((now - prev_edge >= prev_len - 2) && (now - prev_edge <= prev_len + 3),
                          "R2", "frame spacing", now - prev_edge, prev_len);
                if (eq.size() == 0) begin
                    check(0, "R1", "unexpected frame", 0, 1);
                    prev_chk = 0;
                end else begin
                    e = eq.pop_front();
                    mon_busy = 1;
                    ncyc(BITCLK / 2);
                    check(tx_out == 1'b0, "R1", "start bit", int'(tx_out), 0);
                    got = 8'h00;
                    for (int i = 0; i < e.nb; i++) begin
                        ncyc(BITCLK);
                        got[i] = tx_out;
                    end
                    check(got == e.d, "R1", "data bits", int'(got), int'(e.d));
                    if (e.pe) begin
                        ncyc(BITCLK);
                        check(tx_out == e.pv, e.stick ? "R4" : "R3", "parity bit", int'(tx_out), int'(e.pv));
                    end
                    ncyc(BITCLK);
                    check(tx_out == 1'b1, "R1", "stop bit", int'(tx_out), 1);
                    prev_edge = now;
                    prev_len  = e.flen;
                    prev_chk  = e.chk;
                    mon_busy  = 0;
                end
            end
            last_tx = tx_out;
        end
    end

    task automatic lin_test(input logic [3:0] len);
        int n = 0;
        int t = 0;
        int expv;
        lin_len   = len;
        lin_start = 1'b1;
        @(negedge clk);
        lin_start = 1'b0;
        while (tx_out && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(lin_active == 1'b1, "R9", "lin_active during field", int'(lin_active), 1);
        while (!tx_out && n < 2000) begin
            @(negedge clk);
            n++;
        end
        expv = (int'(len) + 2) * BITCLK;
        check((n >= expv - 2) && (n <= expv + 2), "R9", "break field length", n, expv);
        ncyc(BITCLK / 2);
        check(tx_out == 1'b1 && lin_active == 1'b1, "R9", "delimiter high, still active",
              int'({tx_out, lin_active}), 3);
        ncyc(BITCLK);
        check(lin_active == 1'b0 && tx_empty == 1'b1, "R9", "self clear after delimiter",
              int'({lin_active, tx_empty}), 1);
    endtask

    initial begin
        int p0;
        ncyc(5);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(tx_out == 1'b1, "R11", "tx_out after reset", int'(tx_out), 1);
        check(tx_empty == 1'b1 && hold_empty == 1'b1, "R11", "empty flags after reset",
              int'({tx_empty, hold_empty}), 3);
        check(buf_pop == 1'b0 && cts_flag == 1'b0 && lin_active == 1'b0, "R11", "strobes after reset",
              int'({buf_pop, cts_flag, lin_active}), 0);

        // R1: 8 data bits, no parity, 1 stop
        wl = 2'd3; ss = 0; pe = 0;
        push_byte(8'hA5, 1); push_byte(8'h3C, 0);
        wait_done();

        // R2, R3: 5 bits, even parity, 1.5 stop
        wl = 2'd0; ss = 1; pe = 1; pev = 1;
        push_byte(8'h1F, 1); push_byte(8'h0A, 1); push_byte(8'h15, 0);
        wait_done();

        // R2, R3: 6 bits, odd parity, 2 stop
        wl = 2'd1; ss = 1; pe = 1; pev = 0;
        push_byte(8'h2D, 1); push_byte(8'h12, 0);
        wait_done();

        // R4: 7 bits, stick parity both polarities
        wl = 2'd2; ss = 0; pe = 1; pst = 1; pev = 0;
        push_byte(8'h55, 1); push_byte(8'h2A, 0);
        wait_done();
        pev = 1;
        push_byte(8'h7F, 1); push_byte(8'h00, 0);
        wait_done();

        // R2: 8 bits, 2 stop
        wl = 2'd3; ss = 1; pe = 0; pst = 0;
        push_byte(8'h81, 1); push_byte(8'hFF, 0);
        wait_done();

        // R10: flag timing around the last stop bit
        ss = 0;
        push_byte(8'h96, 0);
        wait_pop_to(0);
        ncyc(150);
        check(hold_empty == 1'b1, "R10", "hold_empty after pop", int'(hold_empty), 1);
        check(tx_empty == 1'b0, "R10", "tx_empty low during stop bit", int'(tx_empty), 0);
        ncyc(20);
        check(tx_empty == 1'b1, "R10", "tx_empty after stop bit", int'(tx_empty), 1);
        wait_done();

        // R8, R6: active-low CTS held inactive
        flow = 1; acth = 0; cts_in = 1;
        ncyc(6);
        check(cts_flag == 1'b1, "R8", "flag on rising CTS", int'(cts_flag), 1);
        cts_clr = 1; @(negedge clk); cts_clr = 0;
        @(negedge clk);
        check(cts_flag == 1'b0, "R8", "flag cleared", int'(cts_flag), 0);
        p0 = pops;
        push_byte(8'h5A, 0);
        ncyc(300);
        check(pops == p0, "R6", "no pop while CTS inactive", pops - p0, 0);
        check(tx_out == 1'b1 && hold_empty == 1'b0, "R6", "line idle, byte waiting",
              int'({tx_out, hold_empty}), 2);
        cts_in = 0;
        wait_done();
        check(pops == p0 + 1, "R6", "resume when CTS active low", pops - p0, 1);
        check(cts_flag == 1'b1, "R8", "flag on falling CTS", int'(cts_flag), 1);

        // R6: active-high polarity
        acth = 1;
        p0 = pops;
        push_byte(8'h33, 0);
        ncyc(200);
        check(pops == p0, "R6", "no pop while CTS low (active high)", pops - p0, 0);
        cts_in = 1;
        wait_done();
        check(pops == p0 + 1, "R6", "resume when CTS high", pops - p0, 1);

        // R7: CTS drops mid-character
        push_byte(8'hC3, 0); push_byte(8'h3C, 0);
        wait_pop_to(1);
        ncyc(3 * BITCLK);
        cts_in = 0;
        ncyc(400);
        check(bq.size() == 1 && eq.size() == 1, "R7", "second byte held", bq.size(), 1);
        check(tx_out == 1'b1, "R7", "line idle after first char", int'(tx_out), 1);
        cts_in = 1;
        wait_done();
        check(bq.size() == 0, "R7", "second byte sent after CTS", bq.size(), 0);
        flow = 0;
        cts_clr = 1; @(negedge clk); cts_clr = 0;

        // R5: forced space does not stop the framer
        mon_en = 0;
        wl = 2'd3; ss = 0; pe = 0;
        brk = 1;
        ncyc(2);
        check(tx_out == 1'b0, "R5", "pin forced low", int'(tx_out), 0);
        p0 = pops;
        bq.push_back(8'hFF);
        wait_pop_to(0);
        check(pops == p0 + 1, "R5", "byte popped under break", pops - p0, 1);
        ncyc(150);
        check(tx_out == 1'b0 && tx_empty == 1'b0, "R5", "low, frame still running",
              int'({tx_out, tx_empty}), 0);
        ncyc(20);
        check(tx_empty == 1'b1 && tx_out == 1'b0, "R5", "frame ended on time, pin low",
              int'({tx_empty, tx_out}), 2);
        brk = 0;
        ncyc(2);
        check(tx_out == 1'b1, "R5", "pin released", int'(tx_out), 1);

        // R9: LIN break fields
        lin_test(4'd0);
        lin_test(4'd5);
        lin_test(4'd15);
        mon_en = 1;
        ncyc(BITCLK);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule